// File: doc/BRIEF.md
# Packet Crossbar with Batch-Sampling Arbiters and Broadcast

This block is the switching core of a packet hub. Every input port carries a 16-bit word stream together with a mask of the outputs it wants, a broadcast flag and an end-of-packet strobe. Every output port has its own arbiter and its own input selector. A grant lasts for a whole packet, so output words stay contiguous.

Point-to-point arbitration works in batches. An idle arbiter takes a snapshot of every input that is asking for it. It serves that snapshot lowest input number first, and it admits no newcomer until the snapshot is empty. Because of this, a request waits at most one batch. A broadcast request suspends point-to-point arbitration. Each output finishes its current packet and then reports itself free. When every output is free, the controller that sits beside output 0 picks the broadcasting input, and all outputs carry that input until its packet ends.

Top module: `pkt_xbar`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, every `out_vld` bit is 0, including when reset hits in the middle of a transfer.
- R2: A grant of input i on output j takes effect one clock after the request is sampled. From then on, `out_vld[j]`=1, lane j of `out_src` equals i, and lane j of `out_data` equals lane i of `in_data` in the same cycle.
- R3: A grant stays on the same input until the clock edge at which `in_eop` of that input is 1. At that same edge the next batch member is granted, with no idle cycle.
- R4: An arbiter with no grant and an empty batch samples every input currently requesting it (bit i*NPORT+j of `in_req` = input i wants output j) as one batch. It serves the batch lowest input number first.
- R5: A request that appears after its batch was sampled is not served until every remaining member of that batch has been served, even if its input number is lower.
- R6: Different outputs are granted and carry data independently in the same cycles.
- R7: While any `in_bcast` bit is 1, no arbiter starts a new point-to-point grant. A packet already granted runs until its end-of-packet.
- R8: One clock after every output is without a grant, all outputs become valid with `out_src` equal to the lowest-numbered input whose `in_bcast` bit is 1. They stay on that input until its end-of-packet edge.
- R9: Pending broadcasts are served before any further point-to-point grant, lowest input first. Each one starts one idle cycle after the previous one ends.
- R10: `out_vld[j]` is 0 whenever output j has no grant. The `in_req` bits of an input whose `in_bcast` bit is 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | NPORT*DW | Input words, lane i at bits i*DW +: DW |
| in_req | input | NPORT*NPORT | Destination masks, bit i*NPORT+j = input i requests output j |
| in_bcast | input | NPORT | Input i requests a broadcast |
| in_eop | input | NPORT | Input i presents the last word of its packet |
| out_data | output | NPORT*DW | Output words, lane j at bits j*DW +: DW |
| out_vld | output | NPORT | Output j carries a granted word |
| out_src | output | NPORT*$clog2(NPORT) | Input selected by output j |

## Verification
The bench builds the block at its defaults: eight ports and 16-bit lanes. With that setting the whole eight-bit grant and broadcast vectors are in play. A batch of inputs 2, 5 and 7 can face a late request from input 0, which shows that the batch boundary beats plain priority. A broadcast has to wait for a packet in flight on one output while the other seven outputs sit ready. With these widths, every input lane carries a distinct data word, so a wrong selector setting shows up as a data mismatch.

// File: rtl/xb_pkg.sv
package xb_pkg;
   // index of the lowest set bit; 0 when the vector is empty
   function automatic int unsigned first_set(input logic [31:0] v);
      int unsigned r;
      r = 0;
      for (int k = 31; k >= 0; k--) begin
         if (v[k]) r = k;
      end
      return r;
   endfunction
endpackage

// File: rtl/xb_arbiter.sv
module xb_arbiter
   import xb_pkg::*;
#(
   parameter int N  = 8,
   parameter int IW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req_i,
   input  logic [N-1:0]  eop_i,
   input  logic          bc_pend_i,
   input  logic          bc_act_i,
   output logic          gnt_vld_o,
   output logic [IW-1:0] gnt_src_o,
   output logic          free_o
);
   logic [N-1:0]  batch_q, batch_d;
   logic          gnt_vld_q, gnt_vld_d;
   logic [IW-1:0] gnt_src_q, gnt_src_d;
   logic          done, may_pick;
   logic [N-1:0]  elig, pool, pick_oh;
   logic [IW-1:0] pick;

   always_comb begin
      done      = gnt_vld_q && eop_i[gnt_src_q];
      may_pick  = (!gnt_vld_q || done) && !bc_pend_i && !bc_act_i;
      elig      = batch_q & req_i;
      pool      = (elig != '0) ? elig : req_i;
      pick      = IW'(first_set(32'(pool)));
      pick_oh   = '0;
      pick_oh[pick] = 1'b1;
      gnt_vld_d = gnt_vld_q;
      gnt_src_d = gnt_src_q;
      batch_d   = batch_q;
      if (may_pick && pool != '0) begin
         gnt_vld_d = 1'b1;
         gnt_src_d = pick;
         batch_d   = pool & ~pick_oh;
      end else if (done) begin
         gnt_vld_d = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gnt_vld_q <= 1'b0;
         gnt_src_q <= '0;
         batch_q   <= '0;
      end else begin
         gnt_vld_q <= gnt_vld_d;
         gnt_src_q <= gnt_src_d;
         batch_q   <= batch_d;
      end
   end

   assign gnt_vld_o = gnt_vld_q;
   assign gnt_src_o = gnt_src_q;
   assign free_o    = !gnt_vld_q;

   assert_grant_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_vld_q && !eop_i[gnt_src_q] |=> gnt_vld_q && $stable(gnt_src_q));
   assert_no_grant_in_bcast_R7: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_vld_q |-> !bc_act_i);
   assert_no_new_grant_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !gnt_vld_q && bc_pend_i |=> !gnt_vld_q);
endmodule

// File: rtl/xb_bcast_leader.sv
module xb_bcast_leader
   import xb_pkg::*;
#(
   parameter int N  = 8,
   parameter int IW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  bc_req_i,
   input  logic [N-1:0]  eop_i,
   input  logic [N-1:0]  free_i,
   output logic          pend_o,
   output logic          act_o,
   output logic [IW-1:0] src_o
);
   logic          act_q;
   logic [IW-1:0] src_q;
   logic          start;

   assign pend_o = |bc_req_i;
   assign start  = pend_o && (&free_i) && !act_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         src_q <= '0;
      end else if (start) begin
         act_q <= 1'b1;
         src_q <= IW'(first_set(32'(bc_req_i)));
      end else if (act_q && eop_i[src_q]) begin
         act_q <= 1'b0;
      end
   end

   assign act_o = act_q;
   assign src_o = src_q;

   assert_bcast_after_barrier_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(act_q) |-> $past(&free_i));
   assert_bcast_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      act_q && !eop_i[src_q] |=> act_q && $stable(src_q));
endmodule

// File: rtl/pkt_xbar.sv
module pkt_xbar #(
   parameter int NPORT = 8,
   parameter int DW    = 16,
   localparam int IW   = $clog2(NPORT)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NPORT*DW-1:0]    in_data,
   input  logic [NPORT*NPORT-1:0] in_req,
   input  logic [NPORT-1:0]       in_bcast,
   input  logic [NPORT-1:0]       in_eop,
   output logic [NPORT*DW-1:0]    out_data,
   output logic [NPORT-1:0]       out_vld,
   output logic [NPORT*IW-1:0]    out_src
);
   if (NPORT < 2 || NPORT > 32) begin : g_bad_ports
      $error("pkt_xbar: NPORT must lie in 2..32");
   end
   if (DW < 1) begin : g_bad_width
      $error("pkt_xbar: DW must be positive");
   end

   logic [NPORT-1:0][NPORT-1:0] req_col;
   logic [NPORT-1:0]            gnt_vld, free;
   logic [NPORT-1:0][IW-1:0]    gnt_src;
   logic                        bc_pend, bc_act;
   logic [IW-1:0]               bc_src;

   // column j gathers point-to-point requests aimed at output j
   always_comb begin
      for (int j = 0; j < NPORT; j++) begin
         for (int i = 0; i < NPORT; i++) begin
            req_col[j][i] = in_req[i*NPORT + j] & ~in_bcast[i];
         end
      end
   end

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      logic [IW-1:0] sel;

      xb_arbiter #(.N(NPORT), .IW(IW)) i_arb (
         .clk       (clk),
         .rst_n     (rst_n),
         .req_i     (req_col[p]),
         .eop_i     (in_eop),
         .bc_pend_i (bc_pend),
         .bc_act_i  (bc_act),
         .gnt_vld_o (gnt_vld[p]),
         .gnt_src_o (gnt_src[p]),
         .free_o    (free[p])
      );

      // output 0 carries the broadcast chooser
      if (p == 0) begin : g_lead
         xb_bcast_leader #(.N(NPORT), .IW(IW)) i_lead (
            .clk      (clk),
            .rst_n    (rst_n),
            .bc_req_i (in_bcast),
            .eop_i    (in_eop),
            .free_i   (free),
            .pend_o   (bc_pend),
            .act_o    (bc_act),
            .src_o    (bc_src)
         );
      end

      assign sel                   = bc_act ? bc_src : gnt_src[p];
      assign out_vld[p]            = bc_act | gnt_vld[p];
      assign out_src[p*IW +: IW]   = sel;
      assign out_data[p*DW +: DW]  = in_data[sel*DW +: DW];
   end
endmodule

// File: tb/test_pkt_xbar.sv
`timescale 1ns/1ps
module test_pkt_xbar;
   localparam int N = 8;
   localparam int D = 16;
   localparam int W = 3;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [N*D-1:0] in_data;
   logic [N*N-1:0] in_req = '0;
   logic [N-1:0]   in_bcast = '0;
   logic [N-1:0]   in_eop = '0;
   logic [N*D-1:0] out_data;
   logic [N-1:0]   out_vld;
   logic [N*W-1:0] out_src;
   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   pkt_xbar i_pkt_xbar (
      .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_req(in_req),
      .in_bcast(in_bcast), .in_eop(in_eop), .out_data(out_data),
      .out_vld(out_vld), .out_src(out_src)
   );

   localparam int NV = 6;
   localparam int VSRC [NV] = '{0, 7, 3, 5, 2, 6};
   localparam int VDST [NV] = '{4, 0, 3, 7, 1, 6};
   localparam int VLEN [NV] = '{1, 3, 2, 4, 1, 2};

   function automatic logic [D-1:0] lane_word(int i);
      return 16'h3C00 + 16'(i) * 16'h0111;
   endfunction

   task automatic check(string tag, longint act, longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk_out(string tag, int p, bit vld, int src);
      check({tag, " vld"}, out_vld[p], vld);
      if (vld) begin
         check({tag, " src"}, out_src[p*W +: W], src);
         check({tag, " data"}, out_data[p*D +: D], lane_word(src));
      end
   endtask

   task automatic set_req(int s, int d, bit v);
      in_req[s*N + d] = v;
   endtask

   // end the packet of input s on the next edge
   task automatic finish(int s);
      in_eop[s] = 1'b1;
      step();
      in_eop[s] = 1'b0;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL R1 watchdog expired act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < N; i++) in_data[i*D +: D] = lane_word(i);
      @(negedge clk);
      set_req(1, 2, 1'b1);
      repeat (3) step();
      check("R1 outputs idle in reset", out_vld, 0);
      rst_n = 1'b1;
      set_req(1, 2, 1'b0);
      check("R1 outputs idle after reset", out_vld, 0);

      // R2 table of single routes
      for (int v = 0; v < NV; v++) begin
         set_req(VSRC[v], VDST[v], 1'b1);
         step();
         chk_out("R2 route", VDST[v], 1'b1, VSRC[v]);
         for (int w = 1; w < VLEN[v]; w++) begin
            step();
            chk_out("R3 held", VDST[v], 1'b1, VSRC[v]);
         end
         set_req(VSRC[v], VDST[v], 1'b0);
         finish(VSRC[v]);
         chk_out("R10 released", VDST[v], 1'b0, 0);
      end

      // R4 R5 batch order with a late low-numbered request
      set_req(5, 3, 1'b1); set_req(2, 3, 1'b1); set_req(7, 3, 1'b1);
      step();
      chk_out("R4 lowest of batch", 3, 1'b1, 2);
      set_req(0, 3, 1'b1);
      step();
      chk_out("R3 held", 3, 1'b1, 2);
      set_req(2, 3, 1'b0);
      finish(2);
      chk_out("R3 back-to-back", 3, 1'b1, 5);
      set_req(5, 3, 1'b0);
      finish(5);
      chk_out("R5 late request waits", 3, 1'b1, 7);
      set_req(7, 3, 1'b0);
      finish(7);
      chk_out("R5 new batch", 3, 1'b1, 0);
      set_req(0, 3, 1'b0);
      finish(0);
      chk_out("R10 idle", 3, 1'b0, 0);

      // R6 independent outputs
      set_req(1, 0, 1'b1); set_req(4, 6, 1'b1);
      step();
      chk_out("R6 out0", 0, 1'b1, 1);
      chk_out("R6 out6", 6, 1'b1, 4);
      set_req(1, 0, 1'b0); set_req(4, 6, 1'b0);
      in_eop[1] = 1'b1; in_eop[4] = 1'b1;
      step();
      in_eop = '0;
      check("R10 all idle", out_vld, 0);

      // R7 R8 broadcast waits for a packet in flight
      set_req(6, 2, 1'b1);
      step();
      chk_out("R2 route", 2, 1'b1, 6);
      in_bcast[3] = 1'b1;
      set_req(3, 4, 1'b1);
      step();
      chk_out("R7 packet continues", 2, 1'b1, 6);
      chk_out("R10 bcast mask ignored", 4, 1'b0, 0);
      set_req(1, 5, 1'b1);
      step();
      chk_out("R7 no new grant", 5, 1'b0, 0);
      set_req(6, 2, 1'b0);
      finish(6);
      check("R7 barrier cycle", out_vld, 0);
      step();
      check("R8 all valid", out_vld, 8'hFF);
      for (int p = 0; p < N; p++) chk_out("R8 bcast src", p, 1'b1, 3);
      step();
      chk_out("R8 held", 7, 1'b1, 3);
      in_bcast[3] = 1'b0;
      set_req(3, 4, 1'b0);
      finish(3);
      check("R8 ends", out_vld, 0);
      step();
      chk_out("R9 p2p resumes", 5, 1'b1, 1);
      set_req(1, 5, 1'b0);
      finish(1);

      // R9 two broadcasts beat a point-to-point request
      in_bcast[4] = 1'b1; in_bcast[2] = 1'b1;
      set_req(0, 1, 1'b1);
      step();
      check("R9 all valid", out_vld, 8'hFF);
      for (int p = 0; p < N; p++) chk_out("R9 first bcast", p, 1'b1, 2);
      in_bcast[2] = 1'b0;
      finish(2);
      check("R9 gap", out_vld, 0);
      step();
      for (int p = 0; p < N; p++) chk_out("R9 second bcast", p, 1'b1, 4);
      in_bcast[4] = 1'b0;
      finish(4);
      check("R9 gap", out_vld, 0);
      step();
      chk_out("R9 p2p after bcasts", 1, 1'b1, 0);
      set_req(0, 1, 1'b0);
      finish(0);

      // R1 reset during a transfer
      set_req(2, 7, 1'b1);
      step();
      chk_out("R2 route", 7, 1'b1, 2);
      rst_n = 1'b0;
      set_req(2, 7, 1'b0);
      step();
      check("R1 reset mid packet", out_vld, 0);
      rst_n = 1'b1;
      step();
      check("R1 stays idle", out_vld, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule